// File: doc/BRIEF.md
# Rank-Indexed Growing Counter Bucket

This block keeps one bucket of 64 exact event counters in a small amount of storage. It relies on most counters staying small. Every counter owns one narrow slot in a first-level array. Only a counter that carries out of that slot receives a slot in a shorter second-level array. Only a counter that carries out of both receives a slot in a still shorter third-level array.

No pointers are stored. Each level keeps a bitmap that marks which of its entries continue into the next level. The slot of a counter's next segment is found from the number of set bits in that bitmap at or below the owning position, minus one. When a counter grows, a new slot is inserted at that rank. The entries above the insertion point, and their bitmap bits, move up by one position.

A client issues increment or lookup commands over a valid/ready handshake. Each command returns one response: the full counter value and an overflow flag. The flag is raised when a counter cannot grow, either because the next level has no free slot or because the counter is already at its maximum. In that case the counter is left unchanged. The block runs one command at a time.

Top module: `rank_counter_bucket`

## Requirements
- R1: After reset every counter reads 0, and the lookup response carries rsp_overflow = 0.
- R2: An increment (cmd_incr = 1) adds one to the indexed counter and responds with the new value and rsp_overflow = 0. A lookup (cmd_incr = 0) responds with the current value.
- R3: Carries cross segment boundaries exactly: 2^W1-1 steps to 2^W1, and 2^(W1+W2)-1 steps to 2^(W1+W2). The first such carry of a counter gives it a slot at the next level.
- R4: At most K2 counters may hold values of 2^W1 or more. An increment that would take a further counter from 2^W1-1 to 2^W1 responds with rsp_overflow = 1 and the value 2^W1-1, which is left unchanged.
- R5: At most K3 counters may hold values of 2^(W1+W2) or more. An increment that would take a further counter past 2^(W1+W2)-1 responds with rsp_overflow = 1 and leaves the value at 2^(W1+W2)-1.
- R6: An increment of a counter at 2^(W1+W2+W3)-1 responds with rsp_overflow = 1 and leaves the value unchanged.
- R7: Inserting a slot for one counter, in any order of counter indices, leaves the value of every other counter unchanged.
- R8: rsp_valid is a one-cycle pulse that rises on the fourth rising clock edge after the edge that accepts a command, for both kinds of command.
- R9: cmd_ready is low from the cycle after a command is accepted until the response cycle. It is high in the response cycle.
- R10: A lookup changes no counter. Repeated lookups of a counter return the same value.
- R11: rsp_overflow is 0 on every lookup response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_incr | input | 1 | 1 = increment, 0 = lookup |
| cmd_index | input | $clog2(K) (6) | Counter number |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_value | output | W1+W2+W3 (16) | Counter value after the command |
| rsp_overflow | output | 1 | The increment could not be applied |

## Verification
The hardest state to reach is a full deeper level. To get there, enough distinct counters must be carried across the first and second boundaries that the next expansion has nowhere to go, and those expansions must arrive in an index order that forces inserts into the middle of the packed arrays.

The bench builds a smaller configuration with a 4-bit third level. It pushes seventeen counters past the first boundary in a scrambled index order, then nine of them past the second boundary in another scrambled order, and drives one counter to its ceiling. An arithmetic model predicts every value and overflow flag. Full sweeps of all 64 counters after each phase show that no shift disturbed a neighbour.

// File: rtl/rcb_pkg.sv
`timescale 1ns/1ps
// Shared types for the rank-indexed counter bucket.
package rcb_pkg;
    // Command sequencing: rank at level 2, rank at level 3, apply, respond.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RANK2,
        ST_RANK3,
        ST_APPLY,
        ST_RESP
    } rcb_state_e;
endpackage

// File: rtl/rank_unit.sv
`timescale 1ns/1ps
// rank_unit: inclusive set-bit count of a bitmap up to a position, and the
// total set-bit count. Purely combinational; assumes N >= 2.
module rank_unit #(
    parameter int N = 64,
    localparam int PW = $clog2(N),
    localparam int RW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    input  logic [PW-1:0] pos,
    output logic [RW-1:0] rank,
    output logic [RW-1:0] total
);
    // Sum the bits, counting those at or below pos separately.
    always_comb begin
        rank  = '0;
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + RW'(bits[i]);
            if (PW'(i) <= pos) rank = rank + RW'(bits[i]);
        end
    end
endmodule

// File: rtl/slot_insert.sv
`timescale 1ns/1ps
// slot_insert: returns a packed array of N entries of W bits with val placed
// at index pos and every entry from pos upward moved one index higher; the
// top entry falls off. Assumes the caller only uses it when a slot is free.
module slot_insert #(
    parameter int N = 16,
    parameter int W = 4,
    localparam int PW = $clog2(N)
) (
    input  logic [N*W-1:0] din,
    input  logic [PW-1:0]  pos,
    input  logic [W-1:0]   val,
    output logic [N*W-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        if (i == 0) begin : g_low
            // Entry 0 is either kept or replaced by the new value.
            assign dout[W-1:0] = (pos == '0) ? val : din[W-1:0];
        end else begin : g_up
            // Higher entries keep, take the new value, or take their lower neighbour.
            assign dout[i*W +: W] = (PW'(i) < pos)  ? din[i*W +: W] :
                                    (PW'(i) == pos) ? val : din[(i-1)*W +: W];
        end
    end
endmodule

// File: rtl/rank_counter_bucket.sv
`timescale 1ns/1ps
// rank_counter_bucket: 64 (K) exact counters stored as variable-length
// segment chains over three packed levels. A segment's slot at a deeper level
// is the inclusive rank of its owner's bit in the level bitmap, minus one.
// One command at a time; increments that cannot grow report overflow and
// leave the counter unchanged. Assumes K2*W2 and K3*W3 fit in 64 bits.
module rank_counter_bucket
    import rcb_pkg::*;
#(
    parameter int K  = 64,
    parameter int W1 = 4,
    parameter int K2 = 16,
    parameter int W2 = 4,
    parameter int K3 = 8,
    parameter int W3 = 8,
    localparam int IW  = $clog2(K),
    localparam int VW  = W1 + W2 + W3,
    localparam int S2W = $clog2(K2),
    localparam int S3W = $clog2(K3),
    localparam int RW1 = $clog2(K + 1),
    localparam int RW2 = $clog2(K2 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_incr,
    input  logic [IW-1:0] cmd_index,
    output logic          rsp_valid,
    output logic [VW-1:0] rsp_value,
    output logic          rsp_overflow
);
    // Segment storage and level bitmaps.
    logic [K*W1-1:0]  a1;
    logic [K-1:0]     bm1;
    logic [K2*W2-1:0] a2;
    logic [K2-1:0]    bm2;
    logic [K3*W3-1:0] a3;

    // Per-command registers.
    rcb_state_e      state;
    logic            op_incr;
    logic [IW-1:0]   idx;
    logic [W1-1:0]   seg1;
    logic [W2-1:0]   seg2;
    logic            has2, has3;
    logic [RW1-1:0]  rank2;
    logic [RW2-1:0]  rank3;

    // Combinational helpers.
    logic [RW1-1:0]  rank1_c, cnt2_c;
    logic [RW2-1:0]  rank2_c, cnt3_c;
    logic [S2W-1:0]  slot2, pos2;
    logic [S3W-1:0]  slot3, pos3;
    logic [W3-1:0]   seg3;
    logic [VW-1:0]   old_val, new_val;
    logic [W1-1:0]   nxt1;
    logic [W2-1:0]   nxt2;
    logic [W3-1:0]   nxt3;
    logic            ovf, do_ins2, do_ins3;
    logic [K2*W2-1:0] a2_ins;
    logic [K2-1:0]    bm2_ins;
    logic [K3*W3-1:0] a3_ins;

    assign cmd_ready = (state == ST_IDLE);
    assign slot2 = S2W'(rank2 - RW1'(1));
    assign pos2  = S2W'(rank2);
    assign slot3 = S3W'(rank3 - RW2'(1));
    assign pos3  = S3W'(rank3);
    assign seg3  = has3 ? a3[slot3*W3 +: W3] : '0;
    assign old_val = {seg3, seg2, seg1};

    rank_unit #(.N(K)) u_rank1 (
        .bits(bm1), .pos(idx), .rank(rank1_c), .total(cnt2_c)
    );
    rank_unit #(.N(K2)) u_rank2 (
        .bits(bm2), .pos(slot2), .rank(rank2_c), .total(cnt3_c)
    );
    slot_insert #(.N(K2), .W(W2)) u_ins_a2 (
        .din(a2), .pos(pos2), .val(nxt2), .dout(a2_ins)
    );
    slot_insert #(.N(K2), .W(1)) u_ins_bm2 (
        .din(bm2), .pos(pos2), .val(1'b0), .dout(bm2_ins)
    );
    slot_insert #(.N(K3), .W(W3)) u_ins_a3 (
        .din(a3), .pos(pos3), .val(nxt3), .dout(a3_ins)
    );

    // Increment plan: ripple the carry and decide on expansion or overflow.
    always_comb begin
        ovf     = 1'b0;
        do_ins2 = 1'b0;
        do_ins3 = 1'b0;
        nxt1    = seg1 + W1'(1);
        nxt2    = seg2;
        nxt3    = seg3;
        if (&seg1) begin
            if (!has2) begin
                if (cnt2_c == RW1'(K2)) ovf = 1'b1;
                else begin do_ins2 = 1'b1; nxt2 = W2'(1); end
            end else begin
                nxt2 = seg2 + W2'(1);
                if (&seg2) begin
                    if (!has3) begin
                        if (cnt3_c == RW2'(K3)) ovf = 1'b1;
                        else begin do_ins3 = 1'b1; nxt3 = W3'(1); end
                    end else begin
                        nxt3 = seg3 + W3'(1);
                        if (&seg3) ovf = 1'b1;
                    end
                end
            end
        end
        new_val = ovf ? old_val : {nxt3, nxt2, nxt1};
    end

    // Command sequencer and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            op_incr      <= 1'b0;
            idx          <= '0;
            seg1         <= '0;
            seg2         <= '0;
            has2         <= 1'b0;
            has3         <= 1'b0;
            rank2        <= '0;
            rank3        <= '0;
            rsp_valid    <= 1'b0;
            rsp_value    <= '0;
            rsp_overflow <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    op_incr <= cmd_incr;
                    idx     <= cmd_index;
                    state   <= ST_RANK2;
                end
                ST_RANK2: begin
                    seg1  <= a1[idx*W1 +: W1];
                    has2  <= bm1[idx];
                    rank2 <= rank1_c;
                    state <= ST_RANK3;
                end
                ST_RANK3: begin
                    seg2  <= has2 ? a2[slot2*W2 +: W2] : '0;
                    has3  <= has2 & bm2[slot2];
                    rank3 <= rank2_c;
                    state <= ST_APPLY;
                end
                ST_APPLY: begin
                    rsp_value    <= op_incr ? new_val : old_val;
                    rsp_overflow <= op_incr & ovf;
                    state        <= ST_RESP;
                end
                default: begin
                    rsp_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // Segment storage update on an applicable increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1  <= '0;
            bm1 <= '0;
            a2  <= '0;
            bm2 <= '0;
            a3  <= '0;
        end else if (state == ST_APPLY && op_incr && !ovf) begin
            a1[idx*W1 +: W1] <= nxt1;
            if (do_ins2) begin
                a2       <= a2_ins;
                bm2      <= bm2_ins;
                bm1[idx] <= 1'b1;
            end else if (has2) begin
                a2[slot2*W2 +: W2] <= nxt2;
                if (do_ins3) bm2[slot2] <= 1'b1;
            end
            if (do_ins3)      a3 <= a3_ins;
            else if (has3)    a3[slot3*W3 +: W3] <= nxt3;
        end
    end
endmodule

// File: rtl/rcb_checker.sv
`timescale 1ns/1ps
// rcb_checker: temporal properties of rank_counter_bucket, attached by bind.
module rcb_checker #(
    parameter int K  = 64,
    parameter int K2 = 16,
    parameter int K3 = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          rsp_valid,
    input logic [K-1:0]  bm1,
    input logic [K2-1:0] bm2
);
    logic [2:0] since;

    // Count edges since the last accepted command (1..5, then idle at 0).
    always_ff @(posedge clk) begin
        if (!rst_n)                        since <= '0;
        else if (cmd_valid && cmd_ready)   since <= 3'd1;
        else if (since != 3'd0 && since != 3'd5) since <= since + 3'd1;
        else                               since <= '0;
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rsp_valid == (since == 3'd5)));
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    a_r9_free_at_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> cmd_ready);
    a_r4_level2_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bm1) <= K2);
    a_r5_level3_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bm2) <= K3);
endmodule

bind rank_counter_bucket rcb_checker #(.K(K), .K2(K2), .K3(K3)) u_rcb_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .bm1(bm1), .bm2(bm2)
);

// File: tb/rank_counter_bucket_bench.sv
`timescale 1ns/1ps
// Bench: small configuration (W3 = 4), arithmetic model of every counter.
module rank_counter_bucket_bench;
    localparam int K = 64, W1 = 4, K2 = 16, W2 = 4, K3 = 8, W3 = 4;
    localparam int VW = W1 + W2 + W3;
    localparam int B2 = 1 << W1;
    localparam int B3 = 1 << (W1 + W2);
    localparam int MAXV = (1 << VW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, cmd_incr = 1'b0;
    logic [5:0] cmd_index = '0;
    logic cmd_ready, rsp_valid, rsp_overflow;
    logic [VW-1:0] rsp_value;
    int checks = 0, errors = 0;
    int model [K];

    always #4 clk = ~clk;

    rank_counter_bucket #(.K(K), .W1(W1), .K2(K2), .W2(W2), .K3(K3), .W3(W3)) u_rank_counter_bucket (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_incr(cmd_incr), .cmd_index(cmd_index), .rsp_valid(rsp_valid),
        .rsp_value(rsp_value), .rsp_overflow(rsp_overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic int at_least(input int th);
        int n = 0;
        for (int i = 0; i < K; i++) if (model[i] >= th) n++;
        return n;
    endfunction

    // One command: drive at negedge, measure latency and ready, return result.
    task automatic do_op(input bit incr, input int idx, output int val, output bit ovf);
        int lat;
        bit busy_ok;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_incr  = incr;
        cmd_index = idx[5:0];
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        busy_ok = 1'b1;
        while (!rsp_valid && lat < 20) begin
            if (cmd_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        check(lat == 4, "R8 latency", lat, 4);
        check(busy_ok && cmd_ready, "R9 ready", int'(cmd_ready), 1);
        val = int'(rsp_value);
        ovf = rsp_overflow;
    endtask

    task automatic incr_chk(input int idx);
        int v, ev;
        bit o, eo;
        string tag;
        eo = 1'b0;
        tag = "R2";
        if (model[idx] == MAXV) begin eo = 1'b1; tag = "R6"; end
        else if (model[idx] == B2 - 1) begin
            tag = "R3";
            if (at_least(B2) == K2) begin eo = 1'b1; tag = "R4"; end
        end else if (model[idx] == B3 - 1) begin
            tag = "R3";
            if (at_least(B3) == K3) begin eo = 1'b1; tag = "R5"; end
        end
        ev = eo ? model[idx] : model[idx] + 1;
        do_op(1'b1, idx, v, o);
        check(v == ev, tag, v, ev);
        check(o == eo, {tag, " flag"}, int'(o), int'(eo));
        model[idx] = ev;
    endtask

    task automatic lookup_chk(input int idx, input string tag);
        int v;
        bit o;
        do_op(1'b0, idx, v, o);
        check(v == model[idx], tag, v, model[idx]);
        check(o == 1'b0, "R11", int'(o), 0);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < K; i++) lookup_chk(i, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < K; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R1");
        // Level-2 fill: 17 counters in scrambled order, each crossing 15->16.
        for (int i = 0; i < 17; i++) begin
            int idx = 63 - 3 * ((i * 7) % 17);
            for (int n = 0; n < B2; n++) incr_chk(idx);
        end
        // A counter still in its first slot keeps counting below the boundary.
        for (int n = 0; n < B2; n++) incr_chk(0);
        sweep("R7");
        // Level-3 fill: 9 expanded counters, another scrambled order.
        for (int i = 0; i < 9; i++) begin
            int idx = 63 - 3 * ((i * 4) % 9);
            while (model[idx] < B3 - 1) incr_chk(idx);
            incr_chk(idx);
            incr_chk(idx);
        end
        sweep("R7");
        // R10: repeated lookups see the same value.
        lookup_chk(60, "R10");
        lookup_chk(60, "R10");
        // Drive one counter to its ceiling and beyond.
        while (model[63] < MAXV) incr_chk(63);
        incr_chk(63);
        incr_chk(63);
        sweep("R7");
        report();
    end
endmodule